// File: doc/BRIEF.md
# Per-Branch Local History Direction Predictor

This block predicts whether a conditional branch will be taken by keeping a separate record of each branch's own recent outcomes. A slice of the branch address picks one register in a first-level table of outcome histories. The value of that history is then used, unchanged, as the address into a second-level table of 2-bit saturating counters. The upper bit of the addressed counter is the prediction. Because the counters are addressed only by a branch's own past pattern, repeating patterns such as loop exits are learned per branch.

Lookups arrive on a valid/ready query stream and leave on a valid/ready result stream. The result stream has a single output register. A query is accepted when `q_valid` and `q_ready` are both high. The result is presented on the next cycle and held until the consumer raises `p_ready`. While a result waits, `q_ready` is low, so back-pressure from the consumer stalls the query source. Resolved branches come back on the update stream, which always accepts. Each update trains the counter addressed by the branch's current history and then shifts the outcome into that history. The defaults use a 64-entry first level and a 10-bit history. A 14-bit history, giving 16K counters, is a parameter change.

Top module: `local_hist_predictor`

## Requirements
- R1: The first-level entry is chosen by PC bits [ALIGN_W+IDX_W-1:ALIGN_W] (default bits 7:2). PC bits outside that slice have no effect, so two PCs with equal slices share one history.
- R2: Each first-level entry holds a HIST_W-bit history (default 10) that resets to zero. On an accepted update, the history shifts left by one, the outcome (taken = 1) enters bit 0, and the oldest bit is dropped.
- R3: The selected history value, without hashing, addresses a second-level table of 2^HIST_W counters that all first-level entries share.
- R4: A counter moves up by one on a taken update and down by one on a not-taken update. It stays at 3 on further taken updates and at 0 on further not-taken updates.
- R5: The prediction is taken (p_taken = 1) exactly when the addressed counter holds 2 or 3.
- R6: An update trains the counter addressed by the branch's history as it stood before that update. The outcome is shifted into the history only after that.
- R7: When a query and an update are accepted in the same cycle, the prediction uses the history and counter values from before that update, including when both use the same entry.
- R8: After reset, p_valid is low, every history is zero and every counter holds 1, so every first prediction is not-taken.
- R9: A query is accepted when q_valid and q_ready are both high. p_valid rises on the next cycle. q_ready equals (!p_valid || p_ready), and p_valid and p_taken hold steady while p_ready is low.
- R10: u_ready is always high, and every cycle with u_valid high performs one update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| q_valid | input | 1 | Query request valid |
| q_ready | output | 1 | Query can be accepted this cycle |
| q_pc | input | PC_W | Branch address to predict |
| p_valid | output | 1 | Prediction result valid |
| p_ready | input | 1 | Consumer takes the result |
| p_taken | output | 1 | Predicted direction, 1 = taken |
| u_valid | input | 1 | Resolved branch update valid |
| u_ready | output | 1 | Update accepted, always 1 |
| u_pc | input | PC_W | Address of the resolved branch |
| u_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions assume that reset is held for at least one clock edge and that u_valid and q_valid stay low during reset. They make no assumption about PC values or the order of outcomes. The history-shift and counter-saturation properties only fire when two updates in a row hit the same first-level entry, so the stimulus includes runs of back-to-back updates on a single PC. It also includes long runs of identical outcomes that drive one counter to both limits. Stall checks rely on q_valid being driven while p_ready is low. The stimulus therefore holds p_ready low over several cycles with a second query pending.

// File: rtl/lhp_pkg.sv
`timescale 1ns/1ps
package lhp_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'd0,
    CTR_WEAK_NT   = 2'd1,
    CTR_WEAK_T    = 2'd2,
    CTR_STRONG_T  = 2'd3
  } ctr_e;

  localparam ctr_e CTR_INIT = CTR_WEAK_NT;

  // saturating step of one counter
  function automatic ctr_e ctr_step(ctr_e cur, logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken && cur != CTR_STRONG_T)
      nxt = ctr_e'(cur + 2'd1);
    else if (!taken && cur != CTR_STRONG_NT)
      nxt = ctr_e'(cur - 2'd1);
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(ctr_e c);
    return c[1];
  endfunction

endpackage

// File: rtl/lhp_hist_table.sv
`timescale 1ns/1ps
module lhp_hist_table #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_taken,
  output logic [HIST_W-1:0] wr_hist_old
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        hist_q[e] <= '0;
      else if (wr_en && wr_idx == IDX_W'(e))
        hist_q[e] <= {hist_q[e][HIST_W-2:0], wr_taken};
    end
  end

  assign rd_hist     = hist_q[rd_idx];
  assign wr_hist_old = hist_q[wr_idx];
endmodule

// File: rtl/lhp_ctr_table.sv
`timescale 1ns/1ps
module lhp_ctr_table
  import lhp_pkg::*;
#(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HIST_W-1:0] rd_addr,
  output ctr_e              rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_addr,
  input  logic              wr_taken,
  output ctr_e              wr_ctr_old
);
  localparam int DEPTH = 1 << HIST_W;

  ctr_e ctr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        ctr_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_q[wr_addr] <= ctr_step(ctr_q[wr_addr], wr_taken);
    end
  end

  assign rd_ctr     = ctr_q[rd_addr];
  assign wr_ctr_old = ctr_q[wr_addr];
endmodule

// File: rtl/lhp_resp_reg.sv
`timescale 1ns/1ps
module lhp_resp_reg (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_taken,
  output logic out_valid,
  input  logic out_ready,
  output logic out_taken
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_taken <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_taken <= in_taken;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/local_hist_predictor.sv
`timescale 1ns/1ps
module local_hist_predictor
  import lhp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 6,
  parameter int HIST_W  = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            q_valid,
  output logic            q_ready,
  input  logic [PC_W-1:0] q_pc,
  output logic            p_valid,
  input  logic            p_ready,
  output logic            p_taken,
  input  logic            u_valid,
  output logic            u_ready,
  input  logic [PC_W-1:0] u_pc,
  input  logic            u_taken
);
  localparam int IDX_LO = ALIGN_W;
  localparam int IDX_HI = ALIGN_W + IDX_W - 1;

  logic [IDX_W-1:0]  q_idx, u_idx;
  logic [HIST_W-1:0] q_hist, u_hist;
  ctr_e              q_ctr, u_ctr;
  logic              pc_bits_unused;

  assign q_idx = q_pc[IDX_HI:IDX_LO];
  assign u_idx = u_pc[IDX_HI:IDX_LO];
  assign pc_bits_unused = ^{q_pc[PC_W-1:IDX_HI+1], q_pc[IDX_LO-1:0],
                            u_pc[PC_W-1:IDX_HI+1], u_pc[IDX_LO-1:0]};

  assign u_ready = 1'b1;

  lhp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_hist (
    .clk         (clk),
    .rst         (rst),
    .rd_idx      (q_idx),
    .rd_hist     (q_hist),
    .wr_en       (u_valid),
    .wr_idx      (u_idx),
    .wr_taken    (u_taken),
    .wr_hist_old (u_hist)
  );

  lhp_ctr_table #(.HIST_W(HIST_W)) i_ctr (
    .clk        (clk),
    .rst        (rst),
    .rd_addr    (q_hist),
    .rd_ctr     (q_ctr),
    .wr_en      (u_valid),
    .wr_addr    (u_hist),
    .wr_taken   (u_taken),
    .wr_ctr_old (u_ctr)
  );

  lhp_resp_reg i_resp (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (q_valid),
    .in_ready  (q_ready),
    .in_taken  (ctr_says_taken(q_ctr)),
    .out_valid (p_valid),
    .out_ready (p_ready),
    .out_taken (p_taken)
  );
endmodule

// File: rtl/lhp_checker.sv
`timescale 1ns/1ps
module lhp_checker #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              q_valid,
  input logic              q_ready,
  input logic              p_valid,
  input logic              p_ready,
  input logic              p_taken,
  input logic              u_valid,
  input logic              u_taken,
  input logic [IDX_W-1:0]  u_idx,
  input logic [HIST_W-1:0] u_hist,
  input logic [1:0]        u_ctr,
  input logic [1:0]        q_ctr
);
  AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    q_valid && q_ready |=> p_valid); // R9

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    p_valid && !p_ready |=> p_valid && $stable(p_taken)); // R9

  AST_PRED_FROM_CTR: assert property (@(posedge clk) disable iff (rst)
    q_valid && q_ready |=> p_taken == $past(q_ctr[1])); // R5

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !p_valid); // R8

  AST_HIST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    $past(u_valid) && u_valid && (u_idx == $past(u_idx))
      |-> u_hist == {$past(u_hist[HIST_W-2:0]), $past(u_taken)}); // R2

  AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    $past(u_valid) && u_valid && (u_idx == $past(u_idx)) && $past(u_taken)
      && ($past(u_hist) == {HIST_W{1'b1}}) && (u_hist == {HIST_W{1'b1}})
      |-> (u_ctr == 2'd3) || (u_ctr == $past(u_ctr) + 2'd1)); // R4
endmodule

bind local_hist_predictor lhp_checker #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_lhp_checker (
  .clk     (clk),
  .rst     (rst),
  .q_valid (q_valid),
  .q_ready (q_ready),
  .p_valid (p_valid),
  .p_ready (p_ready),
  .p_taken (p_taken),
  .u_valid (u_valid),
  .u_taken (u_taken),
  .u_idx   (u_idx),
  .u_hist  (u_hist),
  .u_ctr   (u_ctr),
  .q_ctr   (q_ctr)
);

// File: tb/test_local_hist_predictor.sv
`timescale 1ns/1ps
module test_local_hist_predictor;
  localparam int PC_W = 32;
  localparam int ALIGN_W = 2;
  localparam int IDX_W = 6;
  localparam int HIST_W = 10;
  localparam int NENT = 1 << IDX_W;
  localparam int NCTR = 1 << HIST_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic q_valid = 1'b0, p_ready = 1'b1, u_valid = 1'b0, u_taken = 1'b0;
  logic [PC_W-1:0] q_pc = '0, u_pc = '0;
  logic q_ready, p_valid, p_taken, u_ready;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  local_hist_predictor #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .HIST_W(HIST_W))
  i_local_hist_predictor (
    .clk(clk), .rst(rst),
    .q_valid(q_valid), .q_ready(q_ready), .q_pc(q_pc),
    .p_valid(p_valid), .p_ready(p_ready), .p_taken(p_taken),
    .u_valid(u_valid), .u_ready(u_ready), .u_pc(u_pc), .u_taken(u_taken)
  );

  // reference model built from the requirements
  logic [HIST_W-1:0] hist_m [NENT];
  int                ctr_m  [NCTR];

  typedef struct {
    bit    exp;
    string tag;
  } item_t;
  item_t sb[$];

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'((pc >> ALIGN_W) & (NENT - 1));
  endfunction

  function automatic bit model_pred(logic [PC_W-1:0] pc);
    return ctr_m[hist_m[idx_of(pc)]] >= 2;
  endfunction

  task automatic model_update(logic [PC_W-1:0] pc, bit t);
    int i;
    int c;
    i = idx_of(pc);
    c = ctr_m[hist_m[i]];
    if (t) c = (c < 3) ? c + 1 : 3;
    else   c = (c > 0) ? c - 1 : 0;
    ctr_m[hist_m[i]] = c;
    hist_m[i] = {hist_m[i][HIST_W-2:0], t};
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle of stimulus; entered just after a rising edge
  task automatic step(bit qv, logic [PC_W-1:0] qpc, bit uv, logic [PC_W-1:0] upc,
                      bit ut, string tag);
    q_valid = qv; q_pc = qpc; u_valid = uv; u_pc = upc; u_taken = ut;
    @(negedge clk);
    check(u_ready == 1'b1, "R10", int'(u_ready), 1);
    if (qv && q_ready) begin
      item_t it;
      it.exp = model_pred(qpc);
      it.tag = tag;
      sb.push_back(it);
    end
    @(posedge clk); #2;
    if (uv) model_update(upc, ut);
  endtask

  task automatic idle(int n);
    q_valid = 1'b0; u_valid = 1'b0;
    repeat (n) begin
      @(posedge clk); #2;
    end
  endtask

  // monitor: compare results as they are handed over
  always @(negedge clk) begin
    if (!rst && p_valid && p_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected result", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(p_taken == it.exp, it.tag, int'(p_taken), int'(it.exp));
      end
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    bit held;
    for (int i = 0; i < NENT; i++) hist_m[i] = '0;
    for (int i = 0; i < NCTR; i++) ctr_m[i] = 1;

    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(p_valid == 1'b0, "R8 p_valid after reset", int'(p_valid), 0);
    check(q_ready == 1'b1, "R9 q_ready when empty", int'(q_ready), 1);
    @(posedge clk); #2;

    // R8: fresh entries predict not-taken
    step(1, 32'h0000_0040, 0, 0, 0, "R8 fresh");
    step(1, 32'h0000_00FC, 0, 0, 0, "R8 fresh");

    // R2/R6/R4: twelve taken updates on one branch fill history with ones
    for (int k = 0; k < 12; k++)
      step(1, 32'h0000_0104, 1, 32'h0000_0104, 1, "R6 train taken");
    // R1: alias PC with equal index slice but different high and low bits
    step(1, 32'hABC0_0107, 0, 0, 0, "R1 alias shares history");
    // R3: shared counter table seen from another entry
    step(1, 32'h0000_0108, 0, 0, 0, "R3 shared counters");
    // R4: upper saturation then a single not-taken
    for (int k = 0; k < 5; k++)
      step(1, 32'h0000_0104, 1, 32'h0000_0104, 1, "R4 saturate high");
    step(1, 32'h0000_0104, 1, 32'h0000_0104, 0, "R4 one not-taken");
    step(1, 32'h0000_0104, 0, 0, 0, "R5 threshold");
    // R4: lower saturation on a separate branch
    for (int k = 0; k < 16; k++)
      step(1, 32'h0000_0200, 1, 32'h0000_0200, 0, "R4 saturate low");
    step(1, 32'h0000_0200, 1, 32'h0000_0200, 1, "R4 recover from zero");
    step(1, 32'h0000_0200, 0, 0, 0, "R4 after recover");

    // R2/R5: periodic pattern T,T,N learned per branch
    for (int k = 0; k < 60; k++)
      step(1, 32'h0000_0300, 1, 32'h0000_0300, (k % 3) != 2, "R2 periodic pattern");

    // R7: query and update in the same cycle, mixed PCs
    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 300; k++) begin
      logic [PC_W-1:0] qa, ua;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ua = {lfsr[31:16], 8'h0, 2'b00, lfsr[5:3], 3'b000};
      qa = lfsr[7] ? ua : {16'h0, 8'h0, 2'b00, lfsr[11:9], 3'b100};
      step(1, qa, lfsr[8], ua, lfsr[12] | lfsr[13], "R7 same-cycle");
    end
    idle(2);

    // R9: back-pressure
    p_ready = 1'b0;
    step(1, 32'h0000_0104, 0, 0, 0, "R9 stalled result");
    q_valid = 1'b1; q_pc = 32'h0000_0200;
    held = p_taken;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(q_ready == 1'b0, "R9 q_ready under stall", int'(q_ready), 0);
      check(p_valid == 1'b1, "R9 p_valid held", int'(p_valid), 1);
      check(p_taken == held, "R9 p_taken stable", int'(p_taken), int'(held));
      @(posedge clk); #2;
    end
    q_valid = 1'b0;
    p_ready = 1'b1;
    idle(3);
    check(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
    check(p_valid == 1'b0, "R9 p_valid drops", int'(p_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule